// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Unit

This block resolves read-after-write hazards for a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory, writeback. Operands are read in decode and written in writeback, so write-after-read and write-after-write ordering problems cannot arise. Read-after-write is the only hazard the unit handles. The block is purely combinational. It looks at the source register numbers held in the decode and execute stage registers. It also looks at the destination number, write enable and load flag of the instructions further down the pipe.

For each of the two ALU inputs it produces a 2-bit select. The select picks the register-file value, the result held after execute, or the result held after memory. When both later stages carry the needed register, the nearer one wins, because it holds the newer value.

A load delivers its data only at the end of the memory stage. An instruction that uses that data in the very next slot cannot be served by any bypass. In that case the unit freezes the program counter and the fetch/decode register for one cycle and turns the decode/execute load into a bubble. After that single cycle, the loaded value reaches the dependent instruction through the post-memory path.

A third path covers the decode stage. It lets an instruction three slots behind a producer take the value being written back in the same cycle.

Top module: `hazard_unit`

## Requirements
- R1: The ALU operand A select is 2'b10 (post-execute result) when the memory-stage instruction writes a register, is not a load, has a nonzero destination, and that destination equals execute source 1.
- R2: The operand A select is 2'b01 (post-memory result) when the writeback-stage instruction writes a nonzero destination equal to execute source 1 and R1 does not apply. This path also serves a load that has reached writeback.
- R3: When the conditions of both R1 and R2 hold for an operand, the select is 2'b10.
- R4: A destination of register 0, or a write enable of 0, never produces a select other than 2'b00 and never causes a stall. In that case the select is 2'b00 (register file).
- R5: Operand B uses execute source 2 and follows the same rules, independently of operand A.
- R6: When the execute-stage instruction is a load with write enable set, a nonzero destination, and a destination equal to decode source 1 or decode source 2, pcHold, ifidHold and idexBubble are all 1.
- R7: In every other case pcHold, ifidHold and idexBubble are all 0. This includes a non-load producer in execute and a load whose destination matches neither decode source.
- R8: decBypA (decBypB) is 1 exactly when the writeback instruction writes a nonzero destination equal to decode source 1 (source 2).
- R9: A load in the memory stage never selects 2'b10. An operand that matches it takes 2'b01 if writeback matches, and otherwise 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | 5 | Decode-stage source register 1 |
| idRs2 | input | 5 | Decode-stage source register 2 |
| exRs1 | input | 5 | Execute-stage source register 1 |
| exRs2 | input | 5 | Execute-stage source register 2 |
| exRd | input | 5 | Execute-stage destination register |
| exWe | input | 1 | Execute-stage instruction writes a register |
| exLoad | input | 1 | Execute-stage instruction is a load |
| memRd | input | 5 | Memory-stage destination register |
| memWe | input | 1 | Memory-stage instruction writes a register |
| memLoad | input | 1 | Memory-stage instruction is a load |
| wbRd | input | 5 | Writeback-stage destination register |
| wbWe | input | 1 | Writeback-stage instruction writes a register |
| fwdA | output | 2 | ALU operand A select (00 file, 10 post-execute, 01 post-memory) |
| fwdB | output | 2 | ALU operand B select, same encoding |
| decBypA | output | 1 | Decode source 1 takes the writeback value |
| decBypB | output | 1 | Decode source 2 takes the writeback value |
| pcHold | output | 1 | Hold the program counter this cycle |
| ifidHold | output | 1 | Hold the fetch/decode register this cycle |
| idexBubble | output | 1 | Load a bubble into the decode/execute register |

## Verification
The hardest situation to reach is the one where both the memory and the writeback stage name the same register as an execute source. The cases that matter are the memory-stage instruction being a load or not, and one of them targeting register 0. Uniform random register numbers almost never line up this way. The stimulus therefore draws every register number from the range 0 to 3, which forces frequent double matches, r0 destinations and coincident load/stall conditions. Directed vectors then pin down the priority, the load-in-memory exclusion and the load chain after a stall.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int OPS = 2;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } opSel_e;

  typedef struct packed {
    logic pcHold;
    logic ifidHold;
    logic idexBubble;
  } frontCtl_t;

  typedef struct packed {
    logic [OPS-1:0] memHit;
    logic [OPS-1:0] wbHit;
    logic [OPS-1:0] loadHit;
    logic [OPS-1:0] decHit;
  } hitVec_t;
endpackage

// File: rtl/hz_match.sv
module hz_match
  import hz_pkg::*;
#(
  parameter int IDXW = 5
) (
  input  logic [OPS-1:0][IDXW-1:0] exSrc,
  input  logic [OPS-1:0][IDXW-1:0] idSrc,
  input  logic [IDXW-1:0]          exDst,
  input  logic                     exWe,
  input  logic                     exLoad,
  input  logic [IDXW-1:0]          memDst,
  input  logic                     memWe,
  input  logic                     memLoad,
  input  logic [IDXW-1:0]          wbDst,
  input  logic                     wbWe,
  output hitVec_t                  hits
);
  localparam logic [IDXW-1:0] ZERO_REG = '0;

  logic exLoadLive, memAluLive, wbLive;
  logic [OPS-1:0] memHitV, wbHitV, loadHitV, decHitV;

  // a producer only counts when it really writes a real register
  assign exLoadLive = exWe && exLoad && (exDst != ZERO_REG);
  assign memAluLive = memWe && !memLoad && (memDst != ZERO_REG);
  assign wbLive     = wbWe && (wbDst != ZERO_REG);

  for (genvar g = 0; g < OPS; g++) begin : g_cmp
    assign memHitV[g]  = memAluLive && (memDst == exSrc[g]);
    assign wbHitV[g]   = wbLive && (wbDst == exSrc[g]);
    assign loadHitV[g] = exLoadLive && (exDst == idSrc[g]);
    assign decHitV[g]  = wbLive && (wbDst == idSrc[g]);
  end

  assign hits = '{memHit: memHitV, wbHit: wbHitV, loadHit: loadHitV, decHit: decHitV};
endmodule

// File: rtl/hz_control.sv
module hz_control
  import hz_pkg::*;
(
  input  hitVec_t            hits,
  output logic [OPS-1:0][1:0] selCode,
  output logic [OPS-1:0]     decByp,
  output frontCtl_t          ctl
);
  logic stallNow;

  for (genvar g = 0; g < OPS; g++) begin : g_sel
    opSel_e pick;
    always_comb begin
      if (hits.memHit[g])     pick = SEL_MEM;
      else if (hits.wbHit[g]) pick = SEL_WB;
      else                    pick = SEL_RF;
    end
    assign selCode[g] = pick;
  end

  assign decByp   = hits.decHit;
  assign stallNow = |hits.loadHit;

  always_comb begin
    ctl.pcHold     = stallNow;
    ctl.ifidHold   = stallNow;
    ctl.idexBubble = stallNow;
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hz_pkg::*;
#(
  parameter  int REG_COUNT = 32,
  localparam int IDXW      = $clog2(REG_COUNT)
) (
  input  logic [IDXW-1:0] idRs1,
  input  logic [IDXW-1:0] idRs2,
  input  logic [IDXW-1:0] exRs1,
  input  logic [IDXW-1:0] exRs2,
  input  logic [IDXW-1:0] exRd,
  input  logic            exWe,
  input  logic            exLoad,
  input  logic [IDXW-1:0] memRd,
  input  logic            memWe,
  input  logic            memLoad,
  input  logic [IDXW-1:0] wbRd,
  input  logic            wbWe,
  output logic [1:0]      fwdA,
  output logic [1:0]      fwdB,
  output logic            decBypA,
  output logic            decBypB,
  output logic            pcHold,
  output logic            ifidHold,
  output logic            idexBubble
);
  hitVec_t              hits;
  logic [OPS-1:0][1:0]  selCode;
  logic [OPS-1:0]       decByp;
  frontCtl_t            ctl;

  hz_match #(.IDXW(IDXW)) i_match (
    .exSrc  ({exRs2, exRs1}),
    .idSrc  ({idRs2, idRs1}),
    .exDst  (exRd),
    .exWe   (exWe),
    .exLoad (exLoad),
    .memDst (memRd),
    .memWe  (memWe),
    .memLoad(memLoad),
    .wbDst  (wbRd),
    .wbWe   (wbWe),
    .hits   (hits)
  );

  hz_control i_ctrl (
    .hits   (hits),
    .selCode(selCode),
    .decByp (decByp),
    .ctl    (ctl)
  );

  assign fwdA       = selCode[0];
  assign fwdB       = selCode[1];
  assign decBypA    = decByp[0];
  assign decBypB    = decByp[1];
  assign pcHold     = ctl.pcHold;
  assign ifidHold   = ctl.ifidHold;
  assign idexBubble = ctl.idexBubble;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int IDXW = 5
) (
  input logic [IDXW-1:0] exRs1,
  input logic [IDXW-1:0] exRs2,
  input logic [IDXW-1:0] exRd,
  input logic            exWe,
  input logic [IDXW-1:0] memRd,
  input logic            memWe,
  input logic            memLoad,
  input logic [IDXW-1:0] wbRd,
  input logic            wbWe,
  input logic [1:0]      fwdA,
  input logic [1:0]      fwdB,
  input logic            pcHold,
  input logic            ifidHold,
  input logic            idexBubble
);
  always_comb begin
    if (!$isunknown({exRs1, exRs2, exRd, exWe, memRd, memWe, memLoad, wbRd, wbWe})) begin
      // R1
      sel_code_legal_chk: assert (fwdA != 2'b11 && fwdB != 2'b11);
      // R3
      mem_over_wb_chk: assert (!(memWe && !memLoad && memRd != '0 && memRd == exRs1
                                 && wbWe && wbRd == exRs1) || fwdA == 2'b10);
      // R4
      idle_producers_chk: assert ((memWe || wbWe || exWe) || (fwdA == 2'b00 && fwdB == 2'b00 && !pcHold));
      // R6
      front_ctl_agree_chk: assert (pcHold == ifidHold && ifidHold == idexBubble);
      // R9
      load_not_mem_chk: assert (!(memLoad && !(wbWe && wbRd != '0)) || (fwdA != 2'b10 && fwdB != 2'b10)
                                || !memLoad);
      // R9
      load_mem_excl_chk: assert (!memLoad || (fwdA != 2'b10 && fwdB != 2'b10));
    end
  end
endmodule

bind hazard_unit hazard_unit_chk #(.IDXW(IDXW)) i_chk (
  .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd), .exWe(exWe),
  .memRd(memRd), .memWe(memWe), .memLoad(memLoad),
  .wbRd(wbRd), .wbWe(wbWe), .fwdA(fwdA), .fwdB(fwdB),
  .pcHold(pcHold), .ifidHold(ifidHold), .idexBubble(idexBubble)
);

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic [4:0] idRs1 = 0, idRs2 = 0, exRs1 = 0, exRs2 = 0, exRd = 0, memRd = 0, wbRd = 0;
  logic exWe = 0, exLoad = 0, memWe = 0, memLoad = 0, wbWe = 0;
  logic [1:0] fwdA, fwdB;
  logic decBypA, decBypB, pcHold, ifidHold, idexBubble;

  int total = 0;
  int bad = 0;
  bit done = 0;

  hazard_unit i_hazard_unit (
    .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd),
    .exWe(exWe), .exLoad(exLoad), .memRd(memRd), .memWe(memWe), .memLoad(memLoad),
    .wbRd(wbRd), .wbWe(wbWe), .fwdA(fwdA), .fwdB(fwdB), .decBypA(decBypA),
    .decBypB(decBypB), .pcHold(pcHold), .ifidHold(ifidHold), .idexBubble(idexBubble)
  );

  function automatic logic [1:0] expSel(logic [4:0] src);
    if (memWe && !memLoad && memRd != 0 && memRd == src) return 2'b10;
    if (wbWe && wbRd != 0 && wbRd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic expStall();
    return exWe && exLoad && exRd != 0 && (exRd == idRs1 || exRd == idRs2);
  endfunction

  function automatic logic expDec(logic [4:0] src);
    return wbWe && wbRd != 0 && wbRd == src;
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " fwdA"}, {2'b0, fwdA}, {2'b0, expSel(exRs1)});
    check({tag, " fwdB"}, {2'b0, fwdB}, {2'b0, expSel(exRs2)});
    check({tag, " dec"}, {2'b0, decBypA, decBypB}, {2'b0, expDec(idRs1), expDec(idRs2)});
    check({tag, " stall"}, {1'b0, pcHold, ifidHold, idexBubble}, {4{expStall()}} & 4'b0111);
  endtask

  task automatic apply(logic [4:0] i1, i2, e1, e2, ed, logic ew, el,
                       logic [4:0] md, logic mw, ml, logic [4:0] wd, logic ww);
    @(negedge clk);
    idRs1 = i1; idRs2 = i2; exRs1 = e1; exRs2 = e2; exRd = ed; exWe = ew; exLoad = el;
    memRd = md; memWe = mw; memLoad = ml; wbRd = wd; wbWe = ww;
    #2;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst = 0;
    #1;
    check("R7 reset stall", {1'b0, pcHold, ifidHold, idexBubble}, 4'h0);
    check("R4 reset sel", {fwdA, fwdB}, 4'h0);

    apply(0, 0, 3, 0, 0, 0, 0, 3, 1, 0, 0, 0);
    check("R1 mem fwd", {2'b0, fwdA}, 4'h2);
    apply(0, 0, 4, 0, 0, 0, 0, 0, 0, 0, 4, 1);
    check("R2 wb fwd", {2'b0, fwdA}, 4'h1);
    apply(0, 0, 6, 6, 0, 0, 0, 6, 1, 0, 6, 1);
    check("R3 prio A", {2'b0, fwdA}, 4'h2);
    check("R3 prio B", {2'b0, fwdB}, 4'h2);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1);
    check("R4 r0 dest", {fwdA, fwdB}, 4'h0);
    apply(0, 0, 7, 7, 0, 0, 0, 7, 0, 0, 7, 0);
    check("R4 no write", {fwdA, fwdB}, 4'h0);
    apply(0, 0, 1, 2, 0, 0, 0, 2, 1, 0, 1, 1);
    check("R5 A wb", {2'b0, fwdA}, 4'h1);
    check("R5 B mem", {2'b0, fwdB}, 4'h2);
    apply(9, 0, 0, 0, 9, 1, 1, 0, 0, 0, 0, 0);
    check("R6 stall rs1", {1'b0, pcHold, ifidHold, idexBubble}, 4'h7);
    apply(0, 9, 0, 0, 9, 1, 1, 0, 0, 0, 0, 0);
    check("R6 stall rs2", {1'b0, pcHold, ifidHold, idexBubble}, 4'h7);
    apply(9, 9, 0, 0, 9, 1, 0, 0, 0, 0, 0, 0);
    check("R7 alu no stall", {1'b0, pcHold, ifidHold, idexBubble}, 4'h0);
    apply(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    check("R7 load r0", {1'b0, pcHold, ifidHold, idexBubble}, 4'h0);
    apply(5, 8, 0, 0, 0, 0, 0, 0, 0, 0, 5, 1);
    check("R8 dec A", {2'b0, decBypA, decBypB}, 4'h2);
    apply(9, 0, 9, 0, 0, 0, 0, 9, 1, 1, 0, 0);
    check("R9 load mem", {2'b0, fwdA}, 4'h0);
    apply(0, 0, 9, 0, 0, 0, 0, 9, 1, 1, 9, 1);
    check("R9 load mem wb", {2'b0, fwdA}, 4'h1);
    // load chain after a stall: load now in writeback
    apply(0, 0, 9, 0, 0, 0, 0, 0, 0, 0, 9, 1);
    check("R2 load after stall", {2'b0, fwdA}, 4'h1);

    for (int n = 0; n < 3000; n++) begin
      apply(5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4),
            5'($urandom % 4), 1'($urandom), 1'($urandom), 5'($urandom % 4), 1'($urandom),
            1'($urandom), 5'($urandom % 4), 1'($urandom));
      checkAll("R1 R5 R6 R8 R9 rand");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule